// File: doc/BRIEF.md
# Streaming Moving Average Filter

This block smooths a stream of unsigned samples. Every sample it accepts on its input stream goes into a window that holds the most recent sixteen samples. The block then places the mean of that window on its output stream. It keeps a running total instead of re-adding the window each time. For each accepted sample it adds the new value and removes the value that falls out of the window. It forms the mean by dropping the low four bits of the total, so no divider is needed.

Both sides use a valid/ready handshake in the AXI4-Stream style. A single output register sits between the arithmetic and the output port. While that register holds a result the consumer has not taken, the input side reports not-ready. Because of this, no sample is lost when the consumer stalls. After reset the window reads as all zeros. The first fifteen results therefore average the real samples together with zero-filled slots.

Top module: `mavg_filter`

## Requirements
- R1: During reset and on the first cycle after it, `m_tvalid` is 0. `s_tready` is 1 once reset is released.
- R2: Each output value equals floor(S/16), where S is the sum of the last 16 accepted input samples. All are treated as unsigned 16-bit values.
- R3: After reset, slots not yet written count as zero. The k-th result for k < 16 is therefore floor((sum of the first k samples)/16).
- R4: A sample enters the window only on a cycle where `s_tvalid` and `s_tready` are both 1. Data offered in any other cycle has no effect on later outputs.
- R5: A sample accepted at a clock edge produces its result on `m_tvalid`/`m_tdata` immediately after that same edge.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` stays 1 and `m_tdata` keeps its value on the next cycle.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, `s_tready` is 0. Every accepted sample produces exactly one output transfer, in order, with none dropped.
- R8: When `m_tready` is 1, `s_tready` is 1. This allows one sample in and one result out per cycle.
- R9: Once more than 16 samples have been accepted, the oldest sample leaves the window. Sixteen samples of 0xFFFF give exactly 0xFFFF, with no overflow of the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_tvalid | input | 1 | Input sample is offered |
| s_tready | output | 1 | Block can take an input sample |
| s_tdata | input | 16 | Input sample, unsigned |
| m_tvalid | output | 1 | Output average is present |
| m_tready | input | 1 | Consumer takes the output average |
| m_tdata | output | 16 | Window average, unsigned |

## Verification
The bench uses the package defaults: 16-bit samples and a window of 2^4 = 16. At this size, a few hundred cycles cover the zero-filled warm-up, many wraps of the 4-bit write pointer, and a full-scale window of 0xFFFF. The valid and ready inputs follow pseudo-random patterns, so input stalls, output stalls and simultaneous transfers all occur many times. The bench compares each result against a 16-entry window kept in the bench and divided arithmetically.

// File: rtl/mavg_pkg.sv
package mavg_pkg;
    localparam int SAMPLE_W = 16;
    localparam int WIN_LOG2 = 4;
    localparam int WIN      = 1 << WIN_LOG2;
    localparam int SUM_W    = SAMPLE_W + WIN_LOG2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [SUM_W-1:0]    sum_t;
    typedef logic [WIN_LOG2-1:0] ptr_t;

    // one accepted sample and the one it displaces
    typedef struct packed {
        logic    fire;
        sample_t fresh;
        sample_t stale;
    } upd_t;

    function automatic sample_t scale_down(input sum_t total);
        sum_t shifted;
        shifted = total >> WIN_LOG2;
        return shifted[SAMPLE_W-1:0];
    endfunction
endpackage

// File: rtl/mavg_history.sv
module mavg_history
    import mavg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  sample_t din,
    output sample_t oldest
);
    sample_t slots [WIN];
    ptr_t    wr_ptr;

    assign oldest = slots[wr_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            for (int i = 0; i < WIN; i++) slots[i] <= '0;
        end else if (push) begin
            slots[wr_ptr] <= din;
            wr_ptr        <= wr_ptr + ptr_t'(1);
        end
    end
endmodule

// File: rtl/mavg_accum.sv
module mavg_accum
    import mavg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    output sum_t total_next
);
    sum_t total_q;

    always_comb begin
        total_next = total_q + sum_t'(upd.fresh) - sum_t'(upd.stale);
    end

    always_ff @(posedge clk) begin
        if (rst)           total_q <= '0;
        else if (upd.fire) total_q <= total_next;
    end
endmodule

// File: rtl/mavg_outreg.sv
module mavg_outreg
    import mavg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  sample_t avg_in,
    input  logic    take,
    output logic    full,
    output sample_t avg_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            avg_out <= '0;
        end else if (load) begin
            full    <= 1'b1;
            avg_out <= avg_in;
        end else if (take) begin
            full    <= 1'b0;
        end
    end
endmodule

// File: rtl/mavg_filter.sv
module mavg_filter
    import mavg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                s_tvalid,
    output logic                s_tready,
    input  logic [SAMPLE_W-1:0] s_tdata,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic [SAMPLE_W-1:0] m_tdata
);
    logic    accept;
    sample_t stale;
    sum_t    total_next;
    upd_t    upd;

    assign s_tready = !m_tvalid || m_tready;
    assign accept   = s_tvalid && s_tready;

    always_comb begin
        upd.fire  = accept;
        upd.fresh = s_tdata;
        upd.stale = stale;
    end

    mavg_history hist_i (
        .clk    (clk),
        .rst    (rst),
        .push   (accept),
        .din    (s_tdata),
        .oldest (stale)
    );

    mavg_accum acc_i (
        .clk        (clk),
        .rst        (rst),
        .upd        (upd),
        .total_next (total_next)
    );

    mavg_outreg out_i (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .avg_in  (scale_down(total_next)),
        .take    (m_tready),
        .full    (m_tvalid),
        .avg_out (m_tdata)
    );
endmodule

// File: rtl/mavg_filter_chk.sv
module mavg_filter_chk
    import mavg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                s_tvalid,
    input logic                s_tready,
    input logic [SAMPLE_W-1:0] s_tdata,
    input logic                m_tvalid,
    input logic                m_tready,
    input logic [SAMPLE_W-1:0] m_tdata
);
    logic [1:0] pending;
    logic       in_xfer, out_xfer;

    assign in_xfer  = s_tvalid && s_tready;
    assign out_xfer = m_tvalid && m_tready;

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= pending + {1'b0, in_xfer} - {1'b0, out_xfer};
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !m_tvalid);

    // R5
    accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
        in_xfer |=> m_tvalid);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R7
    no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (pending <= 2'd1) && (m_tvalid == (pending == 2'd1)));

    // R8
    throughput_chk: assert property (@(posedge clk) disable iff (rst)
        m_tready |-> s_tready);
endmodule

bind mavg_filter mavg_filter_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tdata  (s_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata)
);

// File: tb/mavg_filter_tb_top.sv
module mavg_filter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [15:0] s_tdata = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic [15:0] m_tdata;

    int checks = 0;
    int fails  = 0;

    int hist [16];
    int wptr = 0;
    int expq [$];
    int seen = 0;

    logic        prev_acc   = 1'b0;
    logic        prev_stall = 1'b0;
    logic [15:0] prev_data  = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mavg_filter dut_i (
        .clk(clk), .rst(rst),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic void model_push(input int d);
        int s;
        hist[wptr] = d;
        wptr = (wptr + 1) % 16;
        s = 0;
        for (int i = 0; i < 16; i++) s += hist[i];
        expq.push_back(s / 16);
    endfunction

    function automatic logic [15:0] next_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // one cycle: checks carried from the last edge, then new inputs
    task automatic step(input bit sv, input logic [15:0] sd, input bit mr, input string req);
        int e;
        @(negedge clk);
        // R5: accept at the last edge shows up right after it
        if (prev_acc) check("R5", m_tvalid == 1'b1, m_tvalid, 1);
        // R6: stalled output is held
        if (prev_stall) begin
            check("R6", m_tvalid == 1'b1, m_tvalid, 1);
            check("R6", m_tdata == prev_data, m_tdata, prev_data);
        end
        s_tvalid = sv;
        s_tdata  = sd;
        m_tready = mr;
        #1;
        if (m_tvalid && !m_tready) check("R7", s_tready == 1'b0, s_tready, 0);
        if (m_tready)              check("R8", s_tready == 1'b1, s_tready, 1);
        if (m_tvalid && m_tready) begin
            if (expq.size() == 0) begin
                check(req, 1'b0, m_tdata, -1);
            end else begin
                e = expq.pop_front();
                check(req, m_tdata == e[15:0], m_tdata, e);
                seen++;
            end
        end
        prev_acc   = s_tvalid && s_tready;
        prev_stall = m_tvalid && !m_tready;
        prev_data  = m_tdata;
        if (s_tvalid && s_tready) model_push(int'(s_tdata));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check("watchdog", 1'b0, 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        // R1: idle during reset
        check("R1", m_tvalid == 1'b0, m_tvalid, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", m_tvalid == 1'b0, m_tvalid, 0);
        check("R1", s_tready == 1'b1, s_tready, 1);

        // R3 warm-up then R2 wrap, full throughput
        for (int i = 1; i <= 40; i++) step(1'b1, 16'(i * 37), 1'b1, (i <= 16) ? "R3" : "R2");
        step(1'b0, 16'h0, 1'b1, "R2");

        // R4: offered data with valid low must be ignored
        for (int i = 0; i < 8; i++) step(1'b0, 16'hFFFF, 1'b1, "R4");
        for (int i = 0; i < 16; i++) step(1'b1, 16'(i), 1'b1, "R4");

        // R7/R6: random valid and ready patterns
        for (int i = 0; i < 600; i++) begin
            lfsr = next_lfsr(lfsr);
            step(lfsr[3] | lfsr[7], lfsr ^ 16'h5A5A, lfsr[1] & ~lfsr[9], "R7");
        end

        // R9: full-scale window
        for (int i = 0; i < 40; i++) step(1'b1, 16'hFFFF, 1'b1, "R9");
        for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b1, "R9");
        check("R9", prev_data == 16'hFFFF, prev_data, 16'hFFFF);

        // R7: every accepted sample came out
        check("R7", expq.size() == 0, expq.size(), 0);
        finish_run();
    end
endmodule